// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block picks the next instruction-fetch address once per cycle for a small signal-processing core. From the current fetch address and the decoded control of the instruction at that address, it selects between straight-line flow, a conditional jump, a conditional subroutine call or return, and the start of a hardware loop. The instruction decoder and the condition logic sit outside; the block sees only one-bit control strobes, a condition-true flag, a target address and a loop count.

Hardware loops close themselves. A loop-start instruction records the first body address on the return-address stack and the last body address with an iteration count on a loop stack. When fetch reaches that last address, the block sends fetch back to the body start without any branch instruction in the program, and once the final pass is done it releases the loop and lets fetch fall through. Loops nest, and the innermost loop is the only one whose end address is compared.

Stack misuse is reported rather than hidden: sticky flags record a push that found its stack full and a pop that found the return-address stack empty. They clear only on reset.

Top module: `zol_sequencer`

## Requirements
- R1: With no control strobe and no loop end reached, `next_pc_o` is `pc_i + 1`, wrapping from 16383 to 0.
- R2: `jump_i` with `cond_i` high gives `next_pc_o = target_i` in the same cycle; with `cond_i` low it gives `pc_i + 1`.
- R3: `call_i` with `cond_i` high gives `target_i` and pushes `pc_i + 1` on the return-address stack; `ret_i` with `cond_i` high gives the top of that stack and pops it; with `cond_i` low neither takes effect.
- R4: When several strobes are high, return wins over call, call over jump, and a taken jump, call or return over a loop start; a taken branch at a loop end address leaves the loop state untouched.
- R5: `do_i` is unconditional: `next_pc_o = pc_i + 1`, the body start `pc_i + 1` is pushed on the return-address stack, and `target_i` (last body address) with `count_i` is pushed on the loop stack; a count of 0 acts as 1.
- R6: When `pc_i` equals the innermost loop end and its count is above 1, `next_pc_o` is the body start and the count drops by one.
- R7: When `pc_i` equals the innermost loop end and its count is 1, `next_pc_o` is `pc_i + 1` and the loop entries are popped from both stacks.
- R8: Loops nest up to 4 deep; only the innermost loop's end address is compared, and an outer loop resumes after an inner one exits.
- R9: The return-address stack holds 16 entries; a call onto a full stack still jumps, drops the push and sets `pc_ovf_o`, which then stays set.
- R10: A loop start that finds the loop stack full sets `loop_ovf_o`, and one that finds the return-address stack full sets `pc_ovf_o`; in either case nothing is pushed on either stack and both flags are sticky.
- R11: A taken return on an empty return-address stack gives `pc_i + 1` and sets the sticky `unf_o`.
- R12: Reset empties both stacks and clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 14 | Current fetch address |
| jump_i | input | 1 | Decoded conditional jump |
| call_i | input | 1 | Decoded conditional call |
| ret_i | input | 1 | Decoded conditional return |
| do_i | input | 1 | Decoded loop start |
| cond_i | input | 1 | Condition evaluated true |
| target_i | input | 14 | Jump/call target, or last loop body address |
| count_i | input | 14 | Loop iteration count |
| next_pc_o | output | 14 | Next fetch address |
| pc_ovf_o | output | 1 | Sticky: push onto full return-address stack |
| loop_ovf_o | output | 1 | Sticky: push onto full loop stack |
| unf_o | output | 1 | Sticky: pop from empty return-address stack |

## Verification
The hardest state to reach is a nest in which an inner loop ends, control falls into the remainder of the outer body and the outer end address then sends fetch back to a start that was pushed several loops earlier, with calls and returns interleaved inside a body. The stimulus feeds each expected next address back as the following `pc_i`, so a walked trace of loop starts, loop ends and branches builds real nests and re-enters an inner loop on the outer loop's second pass. The full-stack cases are reached by directed runs of sixteen calls or four loop starts, after which a return or a loop end shows through `next_pc_o` that the rejected push left no trace.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int unsigned ADDR_W   = 14;
  localparam int unsigned CNT_W    = 14;
  localparam int unsigned PC_DEPTH = 16;
  localparam int unsigned LP_DEPTH = 4;

  typedef enum logic [2:0] {
    ACT_SEQ,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET,
    ACT_DO,
    ACT_LOOP_BACK,
    ACT_LOOP_EXIT
  } act_e;
endpackage

// File: rtl/zol_lifo.sv
module zol_lifo #(
  parameter int unsigned W = 14,
  parameter int unsigned D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  input  logic         upd_i,
  input  logic [W-1:0] upd_data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [PW-1:0] cnt;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == PW'(D));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (push_i && !full_o)  cnt <= cnt + 1'b1;
    else if (pop_i && !empty_o)  cnt <= cnt - 1'b1;
  end

  for (genvar i = 0; i < D; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem[i] <= '0;
      else if (push_i && !full_o && cnt == PW'(i))
        mem[i] <= wdata_i;
      else if (upd_i && !empty_o && cnt == PW'(i + 1))
        mem[i] <= upd_data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < D; i++)
      if (cnt == PW'(i + 1)) top_o = mem[i];
  end
endmodule

// File: rtl/zol_next_addr.sv
module zol_next_addr
  import zol_pkg::*;
#(
  parameter int unsigned AW = 14,
  parameter int unsigned CW = 14
) (
  input  logic [AW-1:0]    pc_i,
  input  logic             jump_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             do_i,
  input  logic             cond_i,
  input  logic [AW-1:0]    target_i,
  input  logic [CW-1:0]    count_i,
  input  logic [AW-1:0]    pc_top_i,
  input  logic             pc_empty_i,
  input  logic             pc_full_i,
  input  logic [AW+CW-1:0] lp_top_i,
  input  logic             lp_empty_i,
  input  logic             lp_full_i,
  output logic [AW-1:0]    next_pc_o,
  output logic             pc_push_o,
  output logic             pc_pop_o,
  output logic [AW-1:0]    pc_wdata_o,
  output logic             lp_push_o,
  output logic             lp_pop_o,
  output logic             lp_upd_o,
  output logic [AW+CW-1:0] lp_wdata_o,
  output logic [AW+CW-1:0] lp_upd_data_o,
  output logic             pc_ovf_ev_o,
  output logic             lp_ovf_ev_o,
  output logic             unf_ev_o
);
  act_e          act;
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] lp_end;
  logic [CW-1:0] lp_cnt;
  logic [CW-1:0] cnt_eff;
  logic          at_end;

  assign pc_inc  = pc_i + 1'b1;
  assign lp_end  = lp_top_i[AW+CW-1:CW];
  assign lp_cnt  = lp_top_i[CW-1:0];
  assign cnt_eff = (count_i == '0) ? CW'(1) : count_i;
  assign at_end  = !lp_empty_i && (pc_i == lp_end);

  // fixed priority: return, call, jump, loop start, loop end
  always_comb begin
    if (ret_i && cond_i)        act = ACT_RET;
    else if (call_i && cond_i)  act = ACT_CALL;
    else if (jump_i && cond_i)  act = ACT_JUMP;
    else if (do_i)              act = ACT_DO;
    else if (at_end)            act = (lp_cnt > CW'(1)) ? ACT_LOOP_BACK : ACT_LOOP_EXIT;
    else                        act = ACT_SEQ;
  end

  always_comb begin
    next_pc_o     = pc_inc;
    pc_push_o     = 1'b0;
    pc_pop_o      = 1'b0;
    pc_wdata_o    = pc_inc;
    lp_push_o     = 1'b0;
    lp_pop_o      = 1'b0;
    lp_upd_o      = 1'b0;
    lp_wdata_o    = {target_i, cnt_eff};
    lp_upd_data_o = {lp_end, lp_cnt - 1'b1};
    pc_ovf_ev_o   = 1'b0;
    lp_ovf_ev_o   = 1'b0;
    unf_ev_o      = 1'b0;
    unique case (act)
      ACT_JUMP: next_pc_o = target_i;
      ACT_CALL: begin
        next_pc_o   = target_i;
        pc_push_o   = !pc_full_i;
        pc_ovf_ev_o = pc_full_i;
      end
      ACT_RET: begin
        if (pc_empty_i) unf_ev_o = 1'b1;
        else begin
          next_pc_o = pc_top_i;
          pc_pop_o  = 1'b1;
        end
      end
      ACT_DO: begin
        pc_ovf_ev_o = pc_full_i;
        lp_ovf_ev_o = lp_full_i;
        pc_push_o   = !pc_full_i && !lp_full_i;
        lp_push_o   = !pc_full_i && !lp_full_i;
      end
      ACT_LOOP_BACK: begin
        lp_upd_o = 1'b1;
        if (pc_empty_i) unf_ev_o = 1'b1;
        else            next_pc_o = pc_top_i;
      end
      ACT_LOOP_EXIT: begin
        lp_pop_o = 1'b1;
        if (pc_empty_i) unf_ev_o = 1'b1;
        else            pc_pop_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned CW       = CNT_W,
  parameter int unsigned PC_DEPTH = zol_pkg::PC_DEPTH,
  parameter int unsigned LP_DEPTH = zol_pkg::LP_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] pc_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          do_i,
  input  logic          cond_i,
  input  logic [AW-1:0] target_i,
  input  logic [CW-1:0] count_i,
  output logic [AW-1:0] next_pc_o,
  output logic          pc_ovf_o,
  output logic          loop_ovf_o,
  output logic          unf_o
);
  localparam int unsigned LW = AW + CW;

  logic [AW-1:0] pc_top, pc_wdata;
  logic          pc_empty, pc_full, pc_push, pc_pop;
  logic [LW-1:0] lp_top, lp_wdata, lp_upd_data;
  logic          lp_empty, lp_full, lp_push, lp_pop, lp_upd;
  logic          pc_ovf_ev, lp_ovf_ev, unf_ev;

  zol_lifo #(.W(AW), .D(PC_DEPTH)) u_pc_stk (
    .clk_i, .rst_ni,
    .push_i     (pc_push),
    .pop_i      (pc_pop),
    .wdata_i    (pc_wdata),
    .upd_i      (1'b0),
    .upd_data_i ('0),
    .top_o      (pc_top),
    .empty_o    (pc_empty),
    .full_o     (pc_full)
  );

  zol_lifo #(.W(LW), .D(LP_DEPTH)) u_lp_stk (
    .clk_i, .rst_ni,
    .push_i     (lp_push),
    .pop_i      (lp_pop),
    .wdata_i    (lp_wdata),
    .upd_i      (lp_upd),
    .upd_data_i (lp_upd_data),
    .top_o      (lp_top),
    .empty_o    (lp_empty),
    .full_o     (lp_full)
  );

  zol_next_addr #(.AW(AW), .CW(CW)) u_nxt (
    .pc_i, .jump_i, .call_i, .ret_i, .do_i, .cond_i, .target_i, .count_i,
    .pc_top_i      (pc_top),
    .pc_empty_i    (pc_empty),
    .pc_full_i     (pc_full),
    .lp_top_i      (lp_top),
    .lp_empty_i    (lp_empty),
    .lp_full_i     (lp_full),
    .next_pc_o,
    .pc_push_o     (pc_push),
    .pc_pop_o      (pc_pop),
    .pc_wdata_o    (pc_wdata),
    .lp_push_o     (lp_push),
    .lp_pop_o      (lp_pop),
    .lp_upd_o      (lp_upd),
    .lp_wdata_o    (lp_wdata),
    .lp_upd_data_o (lp_upd_data),
    .pc_ovf_ev_o   (pc_ovf_ev),
    .lp_ovf_ev_o   (lp_ovf_ev),
    .unf_ev_o      (unf_ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_ovf_o   <= 1'b0;
      loop_ovf_o <= 1'b0;
      unf_o      <= 1'b0;
    end else begin
      if (pc_ovf_ev) pc_ovf_o   <= 1'b1;
      if (lp_ovf_ev) loop_ovf_o <= 1'b1;
      if (unf_ev)    unf_o      <= 1'b1;
    end
  end
endmodule

// File: rtl/zol_sequencer_chk.sv
module zol_sequencer_chk #(
  parameter int unsigned AW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] pc_i,
  input logic          jump_i,
  input logic          call_i,
  input logic          ret_i,
  input logic          do_i,
  input logic          cond_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] next_pc_o,
  input logic          pc_ovf_o,
  input logic          loop_ovf_o,
  input logic          unf_o,
  input logic [AW-1:0] pc_top,
  input logic          pc_empty,
  input logic          pc_full,
  input logic          pc_push,
  input logic          pc_pop,
  input logic          lp_empty,
  input logic          lp_full,
  input logic          lp_push,
  input logic          lp_pop
);
  logic any_br;
  assign any_br = cond_i && (jump_i || call_i || ret_i);

  p_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !call_i && !ret_i && !do_i && lp_empty) |-> next_pc_o == AW'(pc_i + 1'b1));

  p_jump_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && cond_i && !call_i && !ret_i) |-> next_pc_o == target_i);

  p_ret_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && cond_i && !pc_empty) |-> (next_pc_o == pc_top && pc_pop));

  p_br_pri_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_br |-> (!lp_push && !lp_pop));

  p_do_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_i && !any_br) |-> next_pc_o == AW'(pc_i + 1'b1));

  p_ops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_push, pc_pop}) && $onehot0({lp_push, lp_pop}));

  p_ovf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && cond_i && !ret_i && pc_full) |=> pc_ovf_o);

  p_hold_pc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_ovf_o |=> pc_ovf_o);

  p_lpovf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_i && !any_br && lp_full) |-> (!lp_push && !pc_push));

  p_lpovf_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_i && !any_br && lp_full) |=> loop_ovf_o);

  p_hold_lp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_ovf_o |=> loop_ovf_o);

  p_unf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && cond_i && pc_empty) |=> unf_o);

  p_hold_unf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
endmodule

bind zol_sequencer zol_sequencer_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .pc_i, .jump_i, .call_i, .ret_i, .do_i, .cond_i, .target_i,
  .next_pc_o, .pc_ovf_o, .loop_ovf_o, .unf_o,
  .pc_top, .pc_empty, .pc_full, .pc_push, .pc_pop,
  .lp_empty, .lp_full, .lp_push, .lp_pop
);

// File: tb/sim_zol_sequencer.sv
`timescale 1ns/1ps
module sim_zol_sequencer;
  localparam int AW = 14;
  localparam int CW = 14;
  localparam int NV = 54;
  // vector: {req[3:0], {jump,call,ret,do}[3:0], cond, target[13:0], count[13:0], expected[13:0]}
  localparam logic [50:0] VEC [NV] = '{
    {4'd1, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd1},    // R1 pc0
    {4'd2, 4'b1000, 1'b1, 14'd100, 14'd0, 14'd100},  // R2 taken jump
    {4'd2, 4'b1000, 1'b0, 14'd200, 14'd0, 14'd101},  // R2 not taken
    {4'd3, 4'b0100, 1'b1, 14'd300, 14'd0, 14'd300},  // R3 call
    {4'd1, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd301},
    {4'd3, 4'b0010, 1'b1, 14'd0,   14'd0, 14'd102},  // R3 return
    {4'd5, 4'b0001, 1'b0, 14'd104, 14'd3, 14'd103},  // R5 loop 103..104 x3
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd104},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd103},  // R6 back
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd104},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd103},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd104},
    {4'd7, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd105},  // R7 exit
    {4'd7, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd106},
    {4'd8, 4'b0001, 1'b0, 14'd112, 14'd2, 14'd107},  // R8 outer
    {4'd8, 4'b0001, 1'b0, 14'd109, 14'd2, 14'd108},  // R8 inner
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd109},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd108},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd109},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd110},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd111},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd112},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd107},  // R8 outer back
    {4'd8, 4'b0001, 1'b0, 14'd109, 14'd2, 14'd108},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd109},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd108},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd109},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd110},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd111},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd112},
    {4'd8, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd113},  // R8 outer exit
    {4'd3, 4'b0010, 1'b0, 14'd0,   14'd0, 14'd114},  // R3 return not taken
    {4'd5, 4'b0001, 1'b0, 14'd116, 14'd1, 14'd115},
    {4'd7, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd116},
    {4'd7, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd117},  // R7 single pass
    {4'd5, 4'b0001, 1'b0, 14'd120, 14'd2, 14'd118},
    {4'd3, 4'b0100, 1'b1, 14'd400, 14'd0, 14'd400},  // R3 call in body
    {4'd1, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd401},
    {4'd3, 4'b0010, 1'b1, 14'd0,   14'd0, 14'd119},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd120},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd118},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd119},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd120},
    {4'd7, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd121},
    {4'd5, 4'b0001, 1'b0, 14'd122, 14'd0, 14'd122},  // R5 count 0
    {4'd5, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd123},
    {4'd5, 4'b0001, 1'b0, 14'd125, 14'd5, 14'd124},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd125},
    {4'd4, 4'b1000, 1'b1, 14'd124, 14'd0, 14'd124},  // R4 jump at loop end
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd125},
    {4'd6, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd124},
    {4'd4, 4'b1001, 1'b1, 14'd300, 14'd2, 14'd300},  // R4 jump over loop start
    {4'd1, 4'b0000, 1'b0, 14'd0,   14'd0, 14'd301},
    {4'd4, 4'b0110, 1'b1, 14'd600, 14'd0, 14'd124}   // R4 return over call
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, do_i = 1'b0, cond_i = 1'b0;
  logic [AW-1:0] target_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [AW-1:0] next_pc_o;
  logic          pc_ovf_o, loop_ovf_o, unf_o;
  int            checks = 0, fails = 0;

  always #5 clk = ~clk;

  zol_sequencer u0 (
    .clk_i(clk), .rst_ni, .pc_i, .jump_i, .call_i, .ret_i, .do_i, .cond_i,
    .target_i, .count_i, .next_pc_o, .pc_ovf_o, .loop_ovf_o, .unf_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic c, input int pc,
                       input int tgt, input int cnt);
    @(negedge clk);
    {jump_i, call_i, ret_i, do_i} = ctl;
    cond_i   = c;
    pc_i     = AW'(pc);
    target_i = AW'(tgt);
    count_i  = CW'(cnt);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    {jump_i, call_i, ret_i, do_i, cond_i} = '0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pc;
    do_reset();
    pc = 0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][46:43], VEC[i][42], pc, int'(VEC[i][41:28]), int'(VEC[i][27:14]));
      chk(next_pc_o == VEC[i][13:0], $sformatf("R%0d vec%0d", VEC[i][50:47], i),
          int'(next_pc_o), int'(VEC[i][13:0]));
      pc = int'(VEC[i][13:0]);
    end

    // R12: reset clears flags and the loop left active above
    do_reset();
    drive(4'b0000, 1'b0, 125, 0, 0);
    chk(next_pc_o == 14'd126, "R12 loop state cleared", int'(next_pc_o), 126);
    chk(!pc_ovf_o && !loop_ovf_o && !unf_o, "R12 flags clear",
        int'({pc_ovf_o, loop_ovf_o, unf_o}), 0);

    // R1: wrap
    drive(4'b0000, 1'b0, 16383, 0, 0);
    chk(next_pc_o == 14'd0, "R1 wrap", int'(next_pc_o), 0);

    // R11: return on empty stack
    drive(4'b0010, 1'b1, 10, 0, 0);
    chk(next_pc_o == 14'd11, "R11 empty return", int'(next_pc_o), 11);
    drive(4'b0000, 1'b0, 11, 0, 0);
    chk(unf_o, "R11 flag set", int'(unf_o), 1);
    drive(4'b0000, 1'b0, 12, 0, 0);
    drive(4'b0000, 1'b0, 13, 0, 0);
    chk(unf_o, "R11 flag sticky", int'(unf_o), 1);

    // R9: sixteen calls fill the stack, the seventeenth is dropped
    do_reset();
    for (int i = 0; i < 16; i++) begin
      drive(4'b0100, 1'b1, i, 1000 + i, 0);
      chk(next_pc_o == AW'(1000 + i), "R9 call fill", int'(next_pc_o), 1000 + i);
    end
    drive(4'b0000, 1'b0, 50, 0, 0);
    chk(!pc_ovf_o, "R9 no flag at 16", int'(pc_ovf_o), 0);
    drive(4'b0100, 1'b1, 16, 2000, 0);
    chk(next_pc_o == 14'd2000, "R9 call still jumps", int'(next_pc_o), 2000);
    drive(4'b0000, 1'b0, 2000, 0, 0);
    chk(pc_ovf_o, "R9 flag set", int'(pc_ovf_o), 1);
    drive(4'b0010, 1'b1, 2001, 0, 0);
    chk(next_pc_o == 14'd16, "R9 dropped push", int'(next_pc_o), 16);
    drive(4'b0000, 1'b0, 16, 0, 0);
    chk(pc_ovf_o, "R9 flag sticky", int'(pc_ovf_o), 1);

    // R10: do with return-address stack full (15 entries left after the return)
    drive(4'b0100, 1'b1, 20, 3000, 0);
    drive(4'b0001, 1'b0, 500, 600, 2);
    chk(next_pc_o == 14'd501, "R10 do on full pc stack", int'(next_pc_o), 501);
    drive(4'b0000, 1'b0, 600, 0, 0);
    chk(next_pc_o == 14'd601, "R10 nothing pushed", int'(next_pc_o), 601);
    chk(!loop_ovf_o, "R10 loop flag clear", int'(loop_ovf_o), 0);

    // R10 and R8: fifth nested loop start is rejected
    do_reset();
    for (int i = 0; i < 4; i++) begin
      drive(4'b0001, 1'b0, i, 200 + i, 2);
      chk(next_pc_o == AW'(i + 1), "R8 nest push", int'(next_pc_o), i + 1);
    end
    drive(4'b0001, 1'b0, 4, 300, 2);
    chk(next_pc_o == 14'd5, "R10 fifth do", int'(next_pc_o), 5);
    drive(4'b0000, 1'b0, 300, 0, 0);
    chk(next_pc_o == 14'd301, "R10 fifth loop ignored", int'(next_pc_o), 301);
    chk(loop_ovf_o && !pc_ovf_o, "R10 loop flag", int'({loop_ovf_o, pc_ovf_o}), 2);
    drive(4'b0000, 1'b0, 200, 0, 0);
    chk(next_pc_o == 14'd201, "R8 outer end not compared", int'(next_pc_o), 201);
    drive(4'b0000, 1'b0, 203, 0, 0);
    chk(next_pc_o == 14'd4, "R8 innermost back", int'(next_pc_o), 4);
    drive(4'b0000, 1'b0, 4, 0, 0);
    chk(loop_ovf_o, "R10 flag sticky", int'(loop_ovf_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule